// File: doc/BRIEF.md
# Cascadable serial configuration memory reader

This block holds a configuration bitstream in a small internal bit array and streams it out one bit per clock. A sequential address counter starts at zero and moves forward by one on each rising clock edge while the device is selected. Reading ends once the counter has passed a terminal count fixed at build time. After that the counter stays where it is, and the data output enable drops so the output can be treated as three-stated.

A chip-enable output lets several of these readers share a single configuration stream. Each device's chip-enable output feeds the select input of the next device. A downstream device starts streaming only after every device before it has delivered its last bit. One combined input does two jobs. When high it enables the output. When low it resets the device: the counter returns to zero and the chip-enable output is forced inactive.

A configuration input sets the active level of the chip-enable output. A synchronous write port fills the bit array, and the bench uses it for initialisation.

Top module: `cfg_stream_reader`

## Requirements
- R1: While `oe_rst_n` is low at a rising clock edge, the address count is cleared to zero. When `sel` and `oe_rst_n` are then both high, `dout` shows the bit stored at address 0 before the next edge.
- R2: At each rising edge where `sel` is high, `oe_rst_n` is high and the count is at or below `TC`, the count advances by one. While `sel` is low the count holds.
- R3: When the count reaches `TC`+1 it saturates there and never wraps. A device that has been read stays read until `oe_rst_n` goes low.
- R4: `dout_oe` is high exactly when `sel` is high, `oe_rst_n` is high and the count is at or below `TC`. While `dout_oe` is high, `dout` equals the stored bit at the current count. While it is low, `dout` is 0.
- R5: The cascade condition is active exactly when `sel` is high, `oe_rst_n` is high and the count is above `TC`. Once the device has been read, the condition follows `sel` for as long as `oe_rst_n` stays high.
- R6: While `oe_rst_n` is low, the cascade condition is inactive. After `oe_rst_n` returns high it stays inactive until `TC`+1 further bits have been read.
- R7: `casc_out` carries the cascade condition. It is active-high (1 = active) when `casc_pol_high` is 1 and active-low (0 = active) when `casc_pol_high` is 0.
- R8: When `wr_en` is high at a rising edge, `wr_data` is stored at address `wr_addr`. The stored bit is what appears on `dout` when the count later reaches that address.
- R9: `dout_oe` and the cascade condition are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| oe_rst_n | input | 1 | High: output enable; low: synchronous reset of the read position |
| sel | input | 1 | Chip enable, active high, from the previous device or the host |
| casc_pol_high | input | 1 | 1: `casc_out` active-high; 0: `casc_out` active-low |
| wr_en | input | 1 | Write strobe for the bit array |
| wr_addr | input | $clog2(DEPTH) | Write address |
| wr_data | input | 1 | Bit to store |
| dout | output | 1 | Serial data bit; 0 while not enabled |
| dout_oe | output | 1 | Output driver enable for `dout` (low = three-stated) |
| casc_out | output | 1 | Chip enable toward the next device in the chain |

## Verification
The properties are armed only after `oe_rst_n` has been low at one clock edge, because before that the read position is undefined. They also assume `TC` is below `DEPTH`, so every address the counter can read exists in the array. The stimulus opens every run with the reset input low, and it loads the array only while that input is low. It then mixes long selected stretches, which carry the counter into saturation, with pseudo-random dropouts of select and of reset, under both cascade polarities and several stored patterns.

// File: rtl/cfg_stream_pkg.sv
// Package cfg_stream_pkg
// Shared types for the serial configuration reader.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package cfg_stream_pkg;

    // Position of the read pointer relative to the terminal count
    typedef struct packed {
        logic in_range;   // count is at or below the terminal count
        logic past_tc;    // count has moved beyond the terminal count
    } read_pos_t;

    // Active level of the chain enable output
    typedef enum logic {
        CASC_ACTIVE_LOW  = 1'b0,
        CASC_ACTIVE_HIGH = 1'b1
    } casc_pol_e;

endpackage

// File: rtl/cfg_addr_counter.sv
// Module cfg_addr_counter
// Sequential read pointer. Cleared on a clock edge while oe_rst_n is low,
// advances while selected, and saturates one beyond the terminal count.
// Assumes AW is wide enough to hold TC+1.
module cfg_addr_counter
    import cfg_stream_pkg::*;
#(
    parameter int TC = 11,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          oe_rst_n,
    input  logic          sel,
    output logic [AW-1:0] cnt,
    output read_pos_t     pos
);

    localparam logic [AW-1:0] TC_V = AW'(TC);

    logic past_tc;

    // Terminal count detection
    always_comb begin
        past_tc      = (cnt > TC_V);
        pos.past_tc  = past_tc;
        pos.in_range = !past_tc;
    end

    // Pointer update: clear, advance, or hold at saturation
    always_ff @(posedge clk) begin
        if (!oe_rst_n) begin
            cnt <= '0;
        end else if (sel && !past_tc) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_bit_store.sv
// Module cfg_bit_store
// Bit array holding the bitstream, one flop per word built by a generate
// loop. Synchronous write, combinational read.
// Assumes DEPTH is small enough for a flop array.
module cfg_bit_store #(
    parameter int DEPTH = 16,
    parameter int IW    = 4
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    input  logic          wr_data,
    input  logic [IW-1:0] rd_addr,
    output logic          rd_data
);

    logic [DEPTH-1:0] bits;

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        // Store one word when addressed by the write port
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == IW'(w))) begin
                bits[w] <= wr_data;
            end
        end
    end

    // Read the addressed word; out-of-range addresses read 0
    always_comb begin
        rd_data = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_addr == IW'(i)) begin
                rd_data = bits[i];
            end
        end
    end

endmodule

// File: rtl/cfg_chain_enable.sv
// Module cfg_chain_enable
// Output gating: data enable while inside the stream, chain enable once past
// it, with a selectable active level on the chain enable.
// Assumes pos comes from the local read pointer.
module cfg_chain_enable
    import cfg_stream_pkg::*;
(
    input  logic      sel,
    input  logic      oe_rst_n,
    input  logic      pol_high,
    input  read_pos_t pos,
    input  logic      bit_in,
    output logic      dout,
    output logic      dout_oe,
    output logic      casc_out
);

    logic      casc_act;
    casc_pol_e pol;

    // Enable decode for data and chain output
    always_comb begin
        dout_oe  = sel && oe_rst_n && pos.in_range;
        casc_act = sel && oe_rst_n && pos.past_tc;
        dout     = dout_oe ? bit_in : 1'b0;
    end

    // Apply the selected active level
    always_comb begin
        pol      = pol_high ? CASC_ACTIVE_HIGH : CASC_ACTIVE_LOW;
        casc_out = (pol == CASC_ACTIVE_HIGH) ? casc_act : !casc_act;
    end

endmodule

// File: rtl/cfg_stream_reader.sv
// Module cfg_stream_reader
// Top of the cascadable serial configuration reader: read pointer, bit
// array and output gating. Assumes TC < DEPTH.
module cfg_stream_reader
    import cfg_stream_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TC    = 11,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int AW   = $clog2(TC + 2)
) (
    input  logic          clk,
    input  logic          oe_rst_n,
    input  logic          sel,
    input  logic          casc_pol_high,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    input  logic          wr_data,
    output logic          dout,
    output logic          dout_oe,
    output logic          casc_out
);

    logic [AW-1:0] addr_cnt;
    logic [IW-1:0] rd_addr;
    logic          rd_bit;
    read_pos_t     pos;

    cfg_addr_counter #(.TC(TC), .AW(AW)) u_cnt (
        .clk      (clk),
        .oe_rst_n (oe_rst_n),
        .sel      (sel),
        .cnt      (addr_cnt),
        .pos      (pos)
    );

    // Fit the pointer to the array address width
    always_comb rd_addr = IW'(addr_cnt);

    cfg_bit_store #(.DEPTH(DEPTH), .IW(IW)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_bit)
    );

    cfg_chain_enable u_out (
        .sel      (sel),
        .oe_rst_n (oe_rst_n),
        .pol_high (casc_pol_high),
        .pos      (pos),
        .bit_in   (rd_bit),
        .dout     (dout),
        .dout_oe  (dout_oe),
        .casc_out (casc_out)
    );

endmodule

// File: rtl/cfg_stream_reader_chk.sv
// Module cfg_stream_reader_chk
// Property checker bound to cfg_stream_reader. Armed once oe_rst_n has been
// low at a clock edge, since the read pointer is undefined before that.
module cfg_stream_reader_chk #(
    parameter int TC = 11,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          oe_rst_n,
    input logic          sel,
    input logic          casc_pol_high,
    input logic          dout_oe,
    input logic          casc_out,
    input logic [AW-1:0] cnt
);

    localparam logic [AW-1:0] TC_V = AW'(TC);

    logic armed = 1'b0;
    logic casc_on;

    // Arm after the first reset edge
    always_ff @(posedge clk) begin
        if (!oe_rst_n) armed <= 1'b1;
    end

    always_comb casc_on = (casc_out == casc_pol_high);

    p_clear_r1: assert property (@(posedge clk) disable iff (!armed)
        !oe_rst_n |=> (cnt == '0));

    p_advance_r2: assert property (@(posedge clk) disable iff (!armed)
        (oe_rst_n && sel && cnt <= TC_V) |=> (cnt == $past(cnt) + 1'b1));

    p_hold_r2: assert property (@(posedge clk) disable iff (!armed)
        (oe_rst_n && !sel) |=> $stable(cnt));

    p_no_wrap_r3: assert property (@(posedge clk) disable iff (!armed)
        (oe_rst_n && cnt > TC_V) |=> $stable(cnt));

    p_bound_r3: assert property (@(posedge clk) disable iff (!armed)
        cnt <= TC_V + 1'b1);

    p_idle_r4: assert property (@(posedge clk) disable iff (!armed)
        !sel |-> !dout_oe);

    p_rst_inactive_r6: assert property (@(posedge clk) disable iff (!armed)
        !oe_rst_n |-> !casc_on);

    p_exclusive_r9: assert property (@(posedge clk) disable iff (!armed)
        !(dout_oe && casc_on));

endmodule

bind cfg_stream_reader cfg_stream_reader_chk #(.TC(TC), .AW(AW)) u_chk (
    .clk           (clk),
    .oe_rst_n      (oe_rst_n),
    .sel           (sel),
    .casc_pol_high (casc_pol_high),
    .dout_oe       (dout_oe),
    .casc_out      (casc_out),
    .cnt           (addr_cnt)
);

// File: tb/sim_cfg_stream_reader.sv
`timescale 1ns/1ps
module sim_cfg_stream_reader;

    localparam int DEPTH = 16;
    localparam int TC    = 11;
    localparam int IW    = 4;

    logic          clk = 1'b0;
    logic          oe_rst_n = 1'b0;
    logic          sel = 1'b0;
    logic          casc_pol_high = 1'b1;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_addr = '0;
    logic          wr_data = 1'b0;
    logic          dout, dout_oe, casc_out;

    int  nvec = 0;
    int  nbad = 0;
    int  ecnt = 0;
    bit  emem [DEPTH];
    logic [31:0] rs = 32'h1234_5678;

    always #2 clk = ~clk;

    cfg_stream_reader #(.DEPTH(DEPTH), .TC(TC)) u0 (
        .clk(clk), .oe_rst_n(oe_rst_n), .sel(sel), .casc_pol_high(casc_pol_high),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dout(dout), .dout_oe(dout_oe), .casc_out(casc_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs against the arithmetic model of the current cycle
    task automatic compare_outputs();
        bit eoe, eact, ecasc, ed;
        eoe   = sel && oe_rst_n && (ecnt <= TC);
        eact  = sel && oe_rst_n && (ecnt > TC);
        ecasc = casc_pol_high ? eact : !eact;
        ed    = eoe ? emem[ecnt] : 1'b0;
        check(dout_oe == eoe, (ecnt > TC) ? "R3 dout_oe" : "R2 dout_oe", dout_oe, eoe);
        check(dout == ed, "R4 dout", dout, ed);
        check(casc_out == ecasc,
              !oe_rst_n ? "R6 casc_out" : (casc_pol_high ? "R5 casc_out" : "R7 casc_out"),
              casc_out, ecasc);
        check(!(dout_oe && (casc_out == casc_pol_high)), "R9 overlap",
              dout_oe, 0);
    endtask

    // One clock: drive at negedge, check, then update the model after the edge
    task automatic step(input bit s, input bit o);
        @(negedge clk);
        sel = s;
        oe_rst_n = o;
        #1;
        compare_outputs();
        @(posedge clk);
        if (!o) ecnt = 0;
        else if (s && ecnt <= TC) ecnt++;
    endtask

    function automatic bit pattern(input int p, input int i);
        return bit'(((i * (2 * p + 3) + p) >> 1) & 1);
    endfunction

    // Fill the array while held in reset (R8)
    task automatic load(input int p);
        @(negedge clk);
        oe_rst_n = 1'b0;
        sel = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_addr = IW'(i);
            wr_data = pattern(p, i);
            emem[i] = pattern(p, i);
        end
        @(negedge clk);
        wr_en = 1'b0;
        ecnt = 0;
    endtask

    initial begin : main
        // Reset state
        @(posedge clk);
        @(negedge clk);
        #1;
        check(dout_oe == 1'b0, "R6 reset dout_oe", dout_oe, 0);
        check(casc_out == 1'b0, "R6 reset casc_out", casc_out, 0);
        for (int p = 0; p < 3; p++) begin
            for (int pol = 0; pol < 2; pol++) begin
                casc_pol_high = pol[0];
                load(p);
                // First bit right after reset release
                @(negedge clk);
                sel = 1'b1;
                oe_rst_n = 1'b1;
                #1;
                check(dout == emem[0], "R1 first bit", dout, emem[0]);
                check(dout_oe == 1'b1, "R1 first oe", dout_oe, 1);
                @(posedge clk);
                ecnt = 1;
                // Full read into saturation, every stored bit (R8)
                for (int k = 0; k < TC + 6; k++) step(1'b1, 1'b1);
                // Chain enable follows select after read (R5)
                for (int k = 0; k < 6; k++) step(k[0], 1'b1);
                // Reset then confirm inactive until reread (R6)
                step(1'b1, 1'b0);
                step(1'b1, 1'b0);
                for (int k = 0; k < TC + 4; k++) step(1'b1, 1'b1);
                // Pseudo-random select and reset dropouts
                for (int k = 0; k < 250; k++) begin
                    rs ^= rs << 13;
                    rs ^= rs >> 17;
                    rs ^= rs << 5;
                    step(rs[1:0] != 2'b00, rs[7:4] != 4'h0);
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin : watchdog
        #(200000 * 4);
        nbad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule